// File: doc/BRIEF.md
# Centre-Spread Triangular Modulation Profile Generator

This block sits in the reference clock domain. It produces a signed frequency-offset word that steers a downstream fractional divider or phase accumulator. The target is a spread-spectrum clock whose frequency rises and falls in a symmetric triangle around the nominal reference, so the average output frequency equals the reference. The offset is given in parts per 65536 of the nominal frequency. Alongside the word the block gives a direction flag and a one-cycle tick that marks the start of every modulation period. It also brings out a plain copy of the reference clock that is never modulated.

The modulation period is a whole number of reference cycles. A variant strap and a range-select input together choose one of four period lengths. A 6-bit spread code sets the total peak-to-peak spread in steps of 0.1 %. Each quarter of the triangle is built from integer steps. An error accumulator carries the rounding remainder from step to step, so each extreme is reached exactly and the offset always returns to zero. Configuration inputs are taken only at the period tick, so a profile that has started always runs to completion.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the offset is 0, the direction flag is 1 (upward) and the period tick is 1.
- R2: One modulation period lasts D reference cycles, and the tick is high for exactly one cycle in each period. D is chosen by {range_sel, variant}: 00 gives 120, 01 gives 240, 10 gives 480, 11 gives 720.
- R3: The peak magnitude is P = 33 × c, where c is the clamped spread code. At the end of the first quarter the offset is exactly +P, at the end of the third quarter it is exactly −P, and it never leaves [−P, +P].
- R4: Let Q = D/4, and count k cycles from the tick. For j = (k−1) mod Q + 1, define v(j) = ⌊P/Q⌋·j + ⌊(P mod Q)·j/Q⌋. The offset is then 0 at k = 0. For k ≥ 1 it is v, P−v, −v or −(P−v) in quarters 0, 1, 2 and 3, where the quarter is ⌊(k−1)/Q⌋.
- R5: The offset is 0 whenever the tick is high, and its sum over one full period is 0 (centre spread).
- R6: Between consecutive cycles the offset changes by at most ⌊P/Q⌋ + 1.
- R7: The direction flag is 1 while the state quarter ⌊k/Q⌋ is 0 or 3, and 0 while it is 1 or 2.
- R8: range_sel, variant and spread_code are sampled only in the tick cycle. A change made at any other time leaves the current period unchanged and takes effect from the next tick.
- R9: ref_clk_out is the reference clock, unmodulated, at all times.
- R10: Spread codes below 6 act as 6 (0.6 % total), and codes above 40 act as 40 (4.0 % total).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 1 | Range select; drive 1 when left open at board level |
| variant | input | 1 | Device-variant strap: 0 = low range set, 1 = high range set |
| spread_code | input | 6 | Total peak-to-peak spread in 0.1 % units |
| freq_ofs | output | 16 | Signed frequency offset, parts per 65536 |
| dir_up | output | 1 | 1 while the offset is heading upward |
| period_tick | output | 1 | High in the first cycle of each modulation period |
| ref_clk_out | output | 1 | Unmodulated reference clock copy |

## Verification
The bench covers all four period lengths, at the smallest, a middle and the largest spread, and at codes outside the legal range. Each case is compared cycle by cycle against the closed-form triangle. If the remainder accumulator were wrong, the peaks would fall short of ±P or the running sum would drift away from zero. If the quarter sequencing were wrong, the tick spacing, the direction flag or the sign of a quarter would not match. A configuration change in the middle of a period catches a design that samples its inputs outside the tick, because it would bend the rest of that period. Reset is also asserted in the middle of a period, to confirm that the offset returns to centre.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int OFS_W          = 16;
    localparam int CODE_W         = 6;
    localparam int SPREAD_MIN     = 6;
    localparam int SPREAD_MAX     = 40;
    localparam int UNITS_PER_CODE = 33;   // half of 0.1 % of 2^16, rounded
    localparam int DIV_LL         = 120;  // range 0, variant 0
    localparam int DIV_LH         = 240;  // range 0, variant 1
    localparam int DIV_HL         = 480;  // range 1, variant 0
    localparam int DIV_HH         = 720;  // range 1, variant 1

    localparam int CNT_W    = $clog2(DIV_HH / 4);
    localparam int ERR_W    = CNT_W + 1;
    localparam int PEAK_MAX = SPREAD_MAX * UNITS_PER_CODE;
    localparam int PEAK_W   = $clog2(PEAK_MAX + 1);

    typedef logic [CNT_W-1:0]  qcnt_t;
    typedef logic [PEAK_W-1:0] mag_t;

    typedef enum logic [1:0] {
        Q_RISE     = 2'd0,
        Q_FALL_TOP = 2'd1,
        Q_FALL_LOW = 2'd2,
        Q_RISE_LOW = 2'd3
    } quarter_e;

    typedef struct packed {
        qcnt_t qlen;
        mag_t  peak;
        mag_t  step;
        qcnt_t rem;
    } prof_cfg_t;

    function automatic int quarter_len(logic variant, logic sel);
        case ({sel, variant})
            2'b00:   return DIV_LL / 4;
            2'b01:   return DIV_LH / 4;
            2'b10:   return DIV_HL / 4;
            default: return DIV_HH / 4;
        endcase
    endfunction

    function automatic int peak_of(logic [CODE_W-1:0] code);
        int c;
        c = int'(code);
        if (c < SPREAD_MIN)      c = SPREAD_MIN;
        else if (c > SPREAD_MAX) c = SPREAD_MAX;
        return c * UNITS_PER_CODE;
    endfunction

    function automatic prof_cfg_t make_cfg(logic variant, logic sel,
                                           logic [CODE_W-1:0] code);
        prof_cfg_t r;
        int q;
        int p;
        q      = quarter_len(variant, sel);
        p      = peak_of(code);
        r.qlen = qcnt_t'(q);
        r.peak = mag_t'(p);
        r.step = mag_t'(p / q);
        r.rem  = qcnt_t'(p % q);
        return r;
    endfunction

endpackage

// File: rtl/ssc_cfg.sv
module ssc_cfg
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              variant,
    input  logic              range_sel,
    input  logic [CODE_W-1:0] spread_code,
    input  logic              period_tick,
    output prof_cfg_t         cfg_act
);

    prof_cfg_t cfg_in;
    prof_cfg_t cfg_q;

    always_comb cfg_in = make_cfg(variant, range_sel, spread_code);

    always_ff @(posedge clk) begin
        if (rst)              cfg_q <= make_cfg(1'b0, 1'b0, '0);
        else if (period_tick) cfg_q <= cfg_in;
    end

    assign cfg_act = period_tick ? cfg_in : cfg_q;

    // R8: the held configuration moves only on a tick
    assert_hold_between_ticks_R8: assert property (
        @(posedge clk) disable iff (rst)
        !period_tick |=> $stable(cfg_q));

endmodule

// File: rtl/ssc_seq.sv
module ssc_seq
    import ssc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qcnt_t    qlen,
    output quarter_e quarter,
    output logic     last,
    output logic     period_tick,
    output logic     dir_up
);

    qcnt_t    qcnt_q;
    quarter_e quarter_q;

    assign last = (qcnt_q == qlen - qcnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt_q    <= '0;
            quarter_q <= Q_RISE;
        end else if (last) begin
            qcnt_q    <= '0;
            quarter_q <= quarter_e'(quarter_q + 2'd1);
        end else begin
            qcnt_q    <= qcnt_q + qcnt_t'(1);
        end
    end

    assign quarter     = quarter_q;
    assign period_tick = (qcnt_q == '0) && (quarter_q == Q_RISE);
    assign dir_up      = (quarter_q == Q_RISE) || (quarter_q == Q_RISE_LOW);

    // R2: position inside a quarter stays below the quarter length
    assert_qcnt_in_range_R2: assert property (
        @(posedge clk) disable iff (rst)
        qcnt_q < qlen);

    // R2: the tick lasts a single cycle
    assert_tick_single_R2: assert property (
        @(posedge clk) disable iff (rst)
        period_tick |=> !period_tick);

endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
    import ssc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  prof_cfg_t               cfg,
    input  quarter_e                quarter,
    input  logic                    last,
    output logic signed [OFS_W-1:0] ofs
);

    logic [ERR_W-1:0]        err_q;
    logic [ERR_W-1:0]        err_sum;
    logic [ERR_W-1:0]        err_n;
    logic                    wrap;
    mag_t                    inc;
    logic                    rising;
    logic signed [OFS_W-1:0] ofs_q;
    logic signed [OFS_W-1:0] ofs_n;

    always_comb begin
        err_sum = err_q + ERR_W'(cfg.rem);
        wrap    = (err_sum >= ERR_W'(cfg.qlen));
        inc     = cfg.step + mag_t'(wrap);
        if (last)      err_n = '0;
        else if (wrap) err_n = err_sum - ERR_W'(cfg.qlen);
        else           err_n = err_sum;
        rising  = (quarter == Q_RISE) || (quarter == Q_RISE_LOW);
        ofs_n   = rising ? ofs_q + OFS_W'(inc) : ofs_q - OFS_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            ofs_q <= '0;
        end else begin
            err_q <= err_n;
            ofs_q <= ofs_n;
        end
    end

    assign ofs = ofs_q;

    // R3: the offset never leaves the peak band
    assert_within_peak_R3: assert property (
        @(posedge clk) disable iff (rst)
        (int'(ofs_q) <= int'(cfg.peak)) && (int'(ofs_q) >= -int'(cfg.peak)));

    // R3: top extreme is hit exactly at the end of the first quarter
    assert_top_exact_R3: assert property (
        @(posedge clk) disable iff (rst)
        (last && quarter == Q_RISE) |=> (int'(ofs_q) == int'($past(cfg.peak))));

    // R3: bottom extreme is hit exactly at the end of the third quarter
    assert_bottom_exact_R3: assert property (
        @(posedge clk) disable iff (rst)
        (last && quarter == Q_FALL_LOW) |=> (int'(ofs_q) == -int'($past(cfg.peak))));

    // R6: one cycle moves the offset by no more than step + 1
    assert_step_bound_R6: assert property (
        @(posedge clk) disable iff (rst)
        !$past(rst) |->
        (((int'(ofs_q) - int'($past(ofs_q))) <= int'($past(cfg.step)) + 1) &&
         ((int'($past(ofs_q)) - int'(ofs_q)) <= int'($past(cfg.step)) + 1)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    range_sel,
    input  logic                    variant,
    input  logic [CODE_W-1:0]       spread_code,
    output logic signed [OFS_W-1:0] freq_ofs,
    output logic                    dir_up,
    output logic                    period_tick,
    output logic                    ref_clk_out
);

    prof_cfg_t cfg_act;
    quarter_e  quarter;
    logic      last;

    ssc_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .variant     (variant),
        .range_sel   (range_sel),
        .spread_code (spread_code),
        .period_tick (period_tick),
        .cfg_act     (cfg_act)
    );

    ssc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .qlen        (cfg_act.qlen),
        .quarter     (quarter),
        .last        (last),
        .period_tick (period_tick),
        .dir_up      (dir_up)
    );

    ssc_ramp u_ramp (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_act),
        .quarter (quarter),
        .last    (last),
        .ofs     (freq_ofs)
    );

    assign ref_clk_out = clk;

    // R5: every period starts from the centre frequency
    assert_centre_at_tick_R5: assert property (
        @(posedge clk) disable iff (rst)
        period_tick |-> (freq_ofs == '0));

endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              range_sel = 1'b0;
    logic              variant = 1'b0;
    logic [5:0]        spread_code = 6'd6;
    logic signed [15:0] freq_ofs;
    logic              dir_up;
    logic              period_tick;
    logic              ref_clk_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    ssc_profile_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .range_sel   (range_sel),
        .variant     (variant),
        .spread_code (spread_code),
        .freq_ofs    (freq_ofs),
        .dir_up      (dir_up),
        .period_tick (period_tick),
        .ref_clk_out (ref_clk_out)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int qlen_ref(bit v, bit s);
        case ({s, v})
            2'b00:   return 30;
            2'b01:   return 60;
            2'b10:   return 120;
            default: return 180;
        endcase
    endfunction

    function automatic int peak_ref(int code);
        int c;
        c = code;
        if (c < 6)  c = 6;
        if (c > 40) c = 40;
        return 33 * c;
    endfunction

    function automatic int exp_ofs(int k, int q, int pk);
        int qi;
        int j;
        int v;
        if (k == 0) return 0;
        qi = (k - 1) / q;
        j  = (k - 1) % q + 1;
        v  = (pk / q) * j + ((pk % q) * j) / q;
        case (qi)
            0:       return v;
            1:       return pk - v;
            2:       return -v;
            default: return -(pk - v);
        endcase
    endfunction

    task automatic run_period(bit v, bit s, int code, bit mid, string pk_req);
        int q;
        int d;
        int pk;
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        int dirbad = 0;
        int tickbad = 0;
        int mx = -100000;
        int mn = 100000;
        longint sum = 0;
        variant     = v;
        range_sel   = s;
        spread_code = 6'(code);
        while (!period_tick) @(negedge clk);
        q  = qlen_ref(v, s);
        d  = 4 * q;
        pk = peak_ref(code);
        for (int k = 0; k < d; k++) begin
            int a;
            int e;
            bit de;
            a  = int'(freq_ofs);
            e  = exp_ofs(k, q, pk);
            de = ((k / q) == 0) || ((k / q) == 3);
            if (a != e) begin
                if (bad == 0) begin
                    first_act = a;
                    first_exp = e;
                end
                bad++;
            end
            if (dir_up != de) dirbad++;
            if (period_tick != (k == 0)) tickbad++;
            sum += a;
            if (a > mx) mx = a;
            if (a < mn) mn = a;
            if (mid && k == d / 3) begin
                variant     = ~v;
                range_sel   = ~s;
                spread_code = 6'd31;
            end
            @(negedge clk);
        end
        chk(bad == 0, "R4 profile shape", first_act, first_exp);
        if (mid) chk(bad == 0, "R8 mid-period change ignored", first_act, first_exp);
        chk(dirbad == 0, "R7 direction flag", dirbad, 0);
        chk(tickbad == 0 && period_tick == 1'b1, "R2 period length", tickbad, 0);
        chk(sum == 0, "R5 zero mean", int'(sum), 0);
        chk(mx == pk, {pk_req, " positive peak"}, mx, pk);
        chk(mn == -pk, {pk_req, " negative peak"}, mn, -pk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: held in reset
        chk(freq_ofs == 0, "R1 offset in reset", int'(freq_ofs), 0);
        rst = 1'b0;
        // R1: first cycle after release
        chk(freq_ofs == 0, "R1 offset after release", int'(freq_ofs), 0);
        chk(dir_up == 1'b1, "R1 direction after release", int'(dir_up), 1);
        chk(period_tick == 1'b1, "R1 tick after release", int'(period_tick), 1);

        // R9: reference copy follows the clock
        chk(ref_clk_out == 1'b0, "R9 ref copy low", int'(ref_clk_out), 0);
        @(posedge clk);
        #1;
        chk(ref_clk_out == 1'b1, "R9 ref copy high", int'(ref_clk_out), 1);
        @(negedge clk);

        for (int cs = 0; cs < 4; cs++) begin
            run_period(cs[0], cs[1], 6,  1'b0, "R3");
            run_period(cs[0], cs[1], 23, 1'b0, "R3");
            run_period(cs[0], cs[1], 40, 1'b0, "R3");
        end

        // R10: out-of-range codes clamp
        run_period(1'b0, 1'b0, 0,  1'b0, "R10 low clamp");
        run_period(1'b1, 1'b1, 63, 1'b0, "R10 high clamp");

        // R8: change in mid-period, then new configuration at next tick
        run_period(1'b0, 1'b1, 17, 1'b1, "R3");
        run_period(1'b1, 1'b0, 31, 1'b0, "R8 new config");

        // R1: reset in mid-period returns to centre
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(freq_ofs == 0, "R1 offset after mid reset", int'(freq_ofs), 0);
        chk(dir_up == 1'b1, "R1 direction after mid reset", int'(dir_up), 1);
        chk(period_tick == 1'b1, "R1 tick after mid reset", int'(period_tick), 1);
        rst = 1'b0;
        run_period(1'b0, 1'b0, 12, 1'b0, "R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule